// File: doc/BRIEF.md
# MDIO Management Master with Address Scan

This block is a station-management master for the two-wire MDC/MDIO bus used to configure and monitor Ethernet PHYs. It builds clause-22 frames from a small control register. It divides the system clock down to MDC, drives MDIO while it is transmitting, and samples MDIO when a PHY answers. Software can start one write of a 16-bit control word. It can also start one read of a 16-bit status word from a PHY register. The PHY address, register address and write data come from dedicated input words.

A scan mode issues read frames back to back with no software involvement. The scan can hold one PHY address, or it can step the address from a programmed base up to 31 and wrap back to the base. Each read result is stored with the 5-bit address of the PHY that returned it, and a sticky completion flag marks every finished frame. The 32-bit preamble can be left out to shorten each frame.

Top module: `mdio_scan_ctrl`

## Requirements
- R1: After reset the control register reads 00000b, busy and done are 0, and MDIO is not driven (mdio_oe = 0).
- R2: Writing 1 to control bit 0 while idle sends one write frame: preamble, start 01, opcode 01, PHY address = phy_base, register = reg_addr, turnaround 10, then wr_data MSB first. The bit reads back 0 on the following cycle.
- R3: Writing 1 to control bit 1 while idle sends one read frame with opcode 10 at phy_base/reg_addr. MDIO is released from the first turnaround bit to the end of the frame. The 16 bits sampled MSB first land in rd_data, phy_base lands in rd_phy, and bit 1 reads back 0 on the following cycle.
- R4: A write or read trigger that arrives while busy is ignored: no extra frame is sent, rd_data keeps its value, and the trigger bit still clears itself.
- R5: With control bit 2 (scan) set and bit 3 (step) clear, read frames repeat without gaps at phy_base, and each result is reported with rd_phy = phy_base.
- R6: With both scan and step set, successive scan reads use phy_base, phy_base+1, up to 31, then phy_base again.
- R7: Control bit 4 set removes the 32 preamble ones from every frame. When it is clear, exactly 32 driven ones come before the start bits.
- R8: done goes to 1 when any frame completes, with rd_data and rd_phy already updated for a read. A pulse on done_clr returns it to 0. A completion in the same cycle wins over the clear.
- R9: Clearing scan while a scan read is in flight lets that read finish and be reported, after which no further frame starts.
- R10: MDC has a period of 2*HALF_DIV clock cycles. mdio_o and mdio_oe change only on falling MDC edges, and input data is sampled on rising edges.
- R11: busy is 1 from the second cycle after the trigger write until the last data bit has been sent or sampled, and rd_data does not change while busy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Loads ctl_wdata into the control register |
| ctl_wdata | input | 5 | Control: [0] write go, [1] read go, [2] scan, [3] step, [4] no preamble |
| ctl_rdata | output | 5 | Current control register contents |
| phy_base | input | 5 | PHY address for single frames; first address of a scan |
| reg_addr | input | 5 | PHY register address |
| wr_data | input | 16 | Data word for write frames |
| done_clr | input | 1 | Pulse of 1 clears done |
| busy | output | 1 | A frame is on the wire |
| done | output | 1 | Sticky completion flag |
| rd_data | output | 16 | Last word read from a PHY |
| rd_phy | output | 5 | PHY address that rd_data came from |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO line value in |

## Verification
The bench builds the block with HALF_DIV = 2, so MDC runs at a quarter of the system clock and a full 64-bit frame takes about 256 cycles. That leaves room for many complete frames, including a stepping scan that starts at base 29 and passes the wrap from 31 back to the base within five reads. A behavioural PHY on the bench side decodes every frame bit by bit at MDC rising edges. It answers reads with a word built from the PHY and register address, so a wrong address tag or a bit-order error shows up in rd_data.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int CTL_W      = 5;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int POS_W      = $clog2(PRE_BITS + FRAME_BITS);
    localparam int FIDX_W     = $clog2(FRAME_BITS);

    // control register bit positions
    localparam int CB_WR    = 0;
    localparam int CB_RD    = 1;
    localparam int CB_SCAN  = 2;
    localparam int CB_STEP  = 3;
    localparam int CB_NOPRE = 4;

    localparam logic [1:0] ST_CODE = 2'b01;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    typedef struct packed {
        eng_state_e              st;
        logic [POS_W-1:0]        pos;
        logic                    have;
        logic                    rd;
        logic [FRAME_BITS-1:0]   word;
        logic                    oe;
        logic                    dout;
        logic [DATA_W-1:0]       sh;
        logic                    done;
    } eng_regs_t;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [1:0]        go_prev;
        logic [ADDR_W-1:0] job_phy;
        logic              job_rd;
        logic              job_scan;
        logic              done;
        logic [DATA_W-1:0] rd_data;
        logic [ADDR_W-1:0] rd_phy;
    } top_regs_t;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);

    logic wrap;
    logic mdc_d, mdc_q;

    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign wrap = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST) cnt_d = '0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign wrap = (cnt_q == LAST);
        end
    endgenerate

    always_comb begin
        mdc_d = mdc_q;
        if (wrap) mdc_d = ~mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc_d;
    end

    assign mdc_o  = mdc_q;
    assign rise_o = wrap & ~mdc_q;
    assign fall_o = wrap &  mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_read_i,
    input  logic              no_pre_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mdc_rise_i,
    input  logic              mdc_fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);

    localparam int TOTAL = PRE_BITS + FRAME_BITS;
    localparam logic [POS_W-1:0] POS_FRAME = POS_W'(PRE_BITS);
    localparam logic [POS_W-1:0] POS_TA    = POS_W'(PRE_BITS + 4 + 2 * ADDR_W);
    localparam logic [POS_W-1:0] POS_DATA  = POS_W'(TOTAL - DATA_W);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(TOTAL - 1);

    eng_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ENG_IDLE: begin
                // the final bit stays on the wire until the next falling edge
                if (mdc_fall_i) begin
                    d.oe   = 1'b0;
                    d.dout = 1'b1;
                end
                if (start_i) begin
                    d.st   = ENG_RUN;
                    d.pos  = no_pre_i ? POS_FRAME : '0;
                    d.have = 1'b0;
                    d.rd   = is_read_i;
                    d.word = {ST_CODE, (is_read_i ? OP_RD : OP_WR), phy_i, reg_i,
                              TA_WR, wdata_i};
                end
            end
            default: begin
                if (mdc_fall_i) begin
                    d.have = 1'b1;
                    d.oe   = ~q.rd | (q.pos < POS_TA);
                    d.dout = (q.pos < POS_FRAME) ? 1'b1
                                                 : q.word[FIDX_W'(POS_LAST - q.pos)];
                end else if (mdc_rise_i && q.have) begin
                    if (q.rd && (q.pos >= POS_DATA))
                        d.sh = {q.sh[DATA_W-2:0], mdio_i};
                    if (q.pos == POS_LAST) begin
                        d.st   = ENG_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.pos  = q.pos + 1'b1;
                        d.have = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ENG_IDLE, pos: '0, have: 1'b0, rd: 1'b0, word: '0,
                   oe: 1'b0, dout: 1'b1, sh: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.st == ENG_RUN);
    assign done_o    = q.done;
    assign rdata_o   = q.sh;
    assign mdio_o    = q.dout;
    assign mdio_oe_o = q.oe;

endmodule

// File: rtl/mdio_scan_step.sv
module mdio_scan_step
    import mdio_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_i,
    input  logic              step_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] cur_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [ADDR_W-1:0] cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (!scan_i) begin
            cur_d = base_i;
        end else if (advance_i && step_i) begin
            cur_d = (cur_q == TOP_ADDR) ? base_i : cur_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign cur_o = cur_q;

endmodule

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl
    import mdio_scan_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic [ADDR_W-1:0] phy_base,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_clr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_phy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    top_regs_t q, d;

    logic              mdc_rise, mdc_fall;
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic [ADDR_W-1:0] scan_phy;
    logic              wr_rise, rd_rise, eng_free;
    logic              start;
    logic              start_rd;
    logic              start_scan;
    logic [ADDR_W-1:0] start_phy;

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_o  (mdc),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall)
    );

    mdio_scan_step u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_i    (q.ctl[CB_SCAN]),
        .step_i    (q.ctl[CB_STEP]),
        .advance_i (eng_done & q.job_scan),
        .base_i    (phy_base),
        .cur_o     (scan_phy)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .is_read_i  (start_rd),
        .no_pre_i   (q.ctl[CB_NOPRE]),
        .phy_i      (start_phy),
        .reg_i      (reg_addr),
        .wdata_i    (wr_data),
        .mdc_rise_i (mdc_rise),
        .mdc_fall_i (mdc_fall),
        .mdio_i     (mdio_i),
        .busy_o     (eng_busy),
        .done_o     (eng_done),
        .rdata_o    (eng_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe)
    );

    // trigger edges and job selection: write, then read, then scan
    always_comb begin
        wr_rise    = q.ctl[CB_WR] & ~q.go_prev[0];
        rd_rise    = q.ctl[CB_RD] & ~q.go_prev[1];
        eng_free   = ~eng_busy & ~eng_done;
        start      = 1'b0;
        start_rd   = 1'b0;
        start_scan = 1'b0;
        start_phy  = phy_base;
        if (eng_free) begin
            if (wr_rise) begin
                start = 1'b1;
            end else if (rd_rise) begin
                start    = 1'b1;
                start_rd = 1'b1;
            end else if (q.ctl[CB_SCAN]) begin
                start      = 1'b1;
                start_rd   = 1'b1;
                start_scan = 1'b1;
                start_phy  = scan_phy;
            end
        end
    end

    always_comb begin
        d         = q;
        d.go_prev = {q.ctl[CB_RD], q.ctl[CB_WR]};
        if (ctl_we) begin
            d.ctl = ctl_wdata;
        end else begin
            d.ctl[CB_WR] = 1'b0;
            d.ctl[CB_RD] = 1'b0;
        end
        if (start) begin
            d.job_phy  = start_phy;
            d.job_rd   = start_rd;
            d.job_scan = start_scan;
        end
        if (eng_done) begin
            d.done = 1'b1;
            if (q.job_rd) begin
                d.rd_data = eng_rdata;
                d.rd_phy  = q.job_phy;
            end
        end else if (done_clr) begin
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rdata = q.ctl;
    assign busy      = eng_busy;
    assign done      = q.done;
    assign rd_data   = q.rd_data;
    assign rd_phy    = q.rd_phy;

endmodule

// File: rtl/mdio_scan_ctrl_sva.sv
module mdio_scan_ctrl_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [4:0]  ctl_rdata,
    input logic        done_clr,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        eng_done
);

    // R2: write trigger bit clears itself
    a_r2_wr_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && !ctl_we) |=> !ctl_rdata[0]);

    // R3: read trigger bit clears itself
    a_r3_rd_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && !ctl_we) |=> !ctl_rdata[1]);

    // R10: line value and enable move only with falling MDC
    a_r10_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    a_r10_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc));

    // R8: a finished frame raises done on the next cycle
    a_r8_done_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> done);

    // R8: clear without a competing completion drops done
    a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_clr && !eng_done) |=> !done);

    // R11: read result is held while a frame runs
    a_r11_data_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_data));

    // R11: busy ends only when the engine signals the last bit
    a_r11_busy_ends_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> eng_done);

endmodule

bind mdio_scan_ctrl mdio_scan_ctrl_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .done_clr  (done_clr),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .eng_done  (eng_done)
);

// File: tb/mdio_scan_ctrl_tb.sv
module mdio_scan_ctrl_tb;

    localparam int HALF_DIV = 2;
    localparam int WD_LIMIT = 100000;

    // {is_read, no_pre, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [27:0] VEC [0:5] = '{
        {1'b0, 1'b0, 5'd3,  5'd0,  16'hBEEF},
        {1'b1, 1'b0, 5'd3,  5'd1,  16'h0000},
        {1'b0, 1'b1, 5'd31, 5'd31, 16'h8001},
        {1'b1, 1'b1, 5'd0,  5'd2,  16'h0000},
        {1'b0, 1'b0, 5'd17, 5'd9,  16'h0000},
        {1'b1, 1'b0, 5'd31, 5'd30, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [4:0]  ctl_wdata;
    logic [4:0]  ctl_rdata;
    logic [4:0]  phy_base;
    logic [4:0]  reg_addr;
    logic [15:0] wr_data;
    logic        done_clr;
    logic        busy;
    logic        done;
    logic [15:0] rd_data;
    logic [4:0]  rd_phy;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;

    always #5 clk = ~clk;

    assign mdio_i = phy_drv ? phy_bit : 1'b1;

    mdio_scan_ctrl #(.HALF_DIV(HALF_DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .phy_base  (phy_base),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .done_clr  (done_clr),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .rd_phy    (rd_phy),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
        return {3'b101, p, 3'b010, r};
    endfunction

    // ---------------- behavioural PHY ----------------
    int          pst = 0, ones = 0, hcnt = 0, tcnt = 0, pre_w = 0;
    logic [13:0] hdr = '0;
    logic [17:0] tail = '0;
    logic        rd_now = 1'b0, saw_oe = 1'b0;
    logic [15:0] rsp = '0;
    int          p_frames = 0, p_pre = 0;
    logic [1:0]  p_st = '0, p_op = '0, p_ta = '0;
    logic [4:0]  p_phy = '0, p_reg = '0;
    logic [15:0] p_wdata = '0;
    logic        p_rd_oe = 1'b0;

    always @(posedge mdc) begin
        logic line;
        #1;
        line = mdio_oe ? mdio_o : mdio_i;
        if (!rst_n) begin
            pst = 0; ones = 0; phy_drv = 1'b0;
        end else begin
            case (pst)
                0: begin
                    if (mdio_oe && !line) begin
                        hdr = {13'b0, line}; hcnt = 1; pre_w = ones; ones = 0; pst = 1;
                    end else if (mdio_oe) ones++;
                    else ones = 0;
                end
                1: begin
                    hdr = {hdr[12:0], line}; hcnt++;
                    if (hcnt == 14) begin
                        rd_now = (hdr[11:10] == 2'b10);
                        rsp = resp(hdr[9:5], hdr[4:0]);
                        tcnt = 0; saw_oe = 1'b0; pst = 2;
                    end
                end
                default: begin
                    tail = {tail[16:0], line}; tcnt++;
                    if (rd_now && mdio_oe) saw_oe = 1'b1;
                    if (rd_now) begin
                        if (tcnt == 1) begin phy_drv = 1'b1; phy_bit = 1'b0; end
                        else if (tcnt <= 17) phy_bit = rsp[17-tcnt];
                    end
                    if (tcnt == 18) begin
                        phy_drv = 1'b0;
                        p_st = hdr[13:12]; p_op = hdr[11:10];
                        p_phy = hdr[9:5]; p_reg = hdr[4:0];
                        p_ta = tail[17:16]; p_wdata = tail[15:0];
                        p_pre = pre_w; p_rd_oe = saw_oe;
                        p_frames++;
                        pst = 0; ones = 0;
                    end
                end
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic ctl_write(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit ok;
        ok = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        chk(ok, req, 32'(done), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R11 watchdog: actual %0d cycles expected fewer", WD_LIMIT);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [27:0] v;
        logic [4:0]  exp_phy;
        int          f0, c;
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; done_clr = 1'b0;
        phy_base = '0; reg_addr = '0; wr_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ctl_rdata == 5'b0, "R1 ctl", 32'(ctl_rdata), 32'd0);
        chk(!busy, "R1 busy", 32'(busy), 32'd0);
        chk(!done, "R1 done", 32'(done), 32'd0);
        chk(!mdio_oe, "R1 oe", 32'(mdio_oe), 32'd0);

        // R10 MDC period
        while (mdc) @(negedge clk);
        while (!mdc) @(negedge clk);
        c = 0;
        do begin @(negedge clk); c++; end while (mdc);
        do begin @(negedge clk); c++; end while (!mdc);
        chk(c == 2 * HALF_DIV, "R10 mdc period", 32'(c), 32'(2 * HALF_DIV));

        // table of single frames: R2, R3, R7, R8
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            phy_base = v[25:21]; reg_addr = v[20:16]; wr_data = v[15:0];
            f0 = p_frames;
            ctl_write({v[26], 2'b00, v[27], ~v[27]});
            wait_done("R8 done after frame");
            chk(p_frames == f0 + 1, "R2/R3 one frame", 32'(p_frames), 32'(f0 + 1));
            chk(p_st == 2'b01, "R2 start bits", 32'(p_st), 32'd1);
            chk(p_op == (v[27] ? 2'b10 : 2'b01), "R3 opcode", 32'(p_op),
                32'(v[27] ? 2'b10 : 2'b01));
            chk(p_phy == v[25:21], "R2 phy addr", 32'(p_phy), 32'(v[25:21]));
            chk(p_reg == v[20:16], "R2 reg addr", 32'(p_reg), 32'(v[20:16]));
            chk(p_pre == (v[26] ? 0 : 32), "R7 preamble", 32'(p_pre),
                32'(v[26] ? 0 : 32));
            if (v[27]) begin
                chk(rd_data == resp(v[25:21], v[20:16]), "R3 rd_data", 32'(rd_data),
                    32'(resp(v[25:21], v[20:16])));
                chk(rd_phy == v[25:21], "R3 rd_phy", 32'(rd_phy), 32'(v[25:21]));
                chk(!p_rd_oe, "R3 released", 32'(p_rd_oe), 32'd0);
            end else begin
                chk(p_wdata == v[15:0], "R2 wdata", 32'(p_wdata), 32'(v[15:0]));
                chk(p_ta == 2'b10, "R2 turnaround", 32'(p_ta), 32'd2);
            end
            clear_done();
            chk(!done, "R8 done cleared", 32'(done), 32'd0);
        end

        // R2 / R11 self-clear and busy, R4 trigger while busy
        phy_base = 5'd1; reg_addr = 5'd2; wr_data = 16'h1234;
        f0 = p_frames;
        ctl_write(5'b00001);
        chk(ctl_rdata[0], "R2 go loaded", 32'(ctl_rdata), 32'd1);
        @(negedge clk);
        chk(!ctl_rdata[0], "R2 self clear", 32'(ctl_rdata), 32'd0);
        chk(busy, "R11 busy after trigger", 32'(busy), 32'd1);
        repeat (20) @(negedge clk);
        ctl_write(5'b00010);
        @(negedge clk);
        chk(!ctl_rdata[1], "R4 ignored bit clears", 32'(ctl_rdata), 32'd0);
        wait_done("R4 write completes");
        chk(!busy, "R11 busy low at done", 32'(busy), 32'd0);
        clear_done();
        repeat (500) @(negedge clk);
        chk(p_frames == f0 + 1, "R4 no extra frame", 32'(p_frames), 32'(f0 + 1));
        chk(p_op == 2'b01, "R4 frame was write", 32'(p_op), 32'd1);
        chk(rd_data == resp(5'd31, 5'd30), "R4 rd_data kept", 32'(rd_data),
            32'(resp(5'd31, 5'd30)));
        chk(!done && !busy, "R4 stays idle", 32'({done, busy}), 32'd0);

        // R5 fixed-address scan
        phy_base = 5'd5; reg_addr = 5'd7;
        ctl_write(5'b00100);
        for (int i = 0; i < 3; i++) begin
            wait_done("R5 scan read");
            chk(rd_phy == 5'd5, "R5 rd_phy", 32'(rd_phy), 32'd5);
            chk(rd_data == resp(5'd5, 5'd7), "R5 rd_data", 32'(rd_data),
                32'(resp(5'd5, 5'd7)));
            chk(p_pre == 32, "R7 preamble in scan", 32'(p_pre), 32'd32);
            clear_done();
        end

        // R9 stop scan mid-frame
        repeat (50) @(negedge clk);
        chk(busy, "R9 frame in flight", 32'(busy), 32'd1);
        f0 = p_frames;
        ctl_write(5'b00000);
        wait_done("R9 last read reported");
        chk(rd_phy == 5'd5 && rd_data == resp(5'd5, 5'd7), "R9 last result",
            32'(rd_data), 32'(resp(5'd5, 5'd7)));
        clear_done();
        repeat (600) @(negedge clk);
        chk(p_frames == f0 + 1, "R9 no further frame", 32'(p_frames), 32'(f0 + 1));
        chk(!busy && !done, "R9 idle", 32'({busy, done}), 32'd0);

        // R6 stepping scan with wrap, R7 no preamble
        phy_base = 5'd29; reg_addr = 5'd3;
        ctl_write(5'b11100);
        exp_phy = 5'd29;
        for (int i = 0; i < 5; i++) begin
            wait_done("R6 step read");
            chk(rd_phy == exp_phy, "R6 step addr", 32'(rd_phy), 32'(exp_phy));
            chk(rd_data == resp(exp_phy, 5'd3), "R6 step data", 32'(rd_data),
                32'(resp(exp_phy, 5'd3)));
            chk(p_pre == 0, "R7 no preamble", 32'(p_pre), 32'd0);
            clear_done();
            exp_phy = (exp_phy == 5'd31) ? 5'd29 : exp_phy + 5'd1;
        end
        ctl_write(5'b00000);
        wait_done("R9 step scan stop");
        clear_done();
        repeat (300) @(negedge clk);
        chk(!busy, "R9 idle after step scan", 32'(busy), 32'd0);

        finish_run();
    end

endmodule